// File: doc/BRIEF.md
# Power-On Strap Capture and Pin Handover Controller

This block sits between a clock generator's shared pads and its configuration logic. A few pads serve two purposes. While power-on reset is held they carry strap levels set by pull resistors on the board. Once reset ends they become clock outputs. During reset the block keeps every shared pad's output driver off and samples the pad levels on each reference-clock edge. On the first edge after reset is released, it moves the last sample into a configuration register. That register then stays fixed until the next reset.

The captured word holds a frequency-select code and a bus-mode select bit. The frequency-select code is decoded into one of three modes for downstream logic: a normal frequency table, a production test mode, or a mode in which every clock output floats. One cycle after the capture, the block turns on the shared pads' output enables, unless the tristate code was captured. In the same cycle it raises a single-cycle valid strobe. Sampling and driving therefore never overlap.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While `rstActive` is high, `pinOe` is all zeros, and `configValid`, `modeNormal`, `modeTest` and `modeTristate` are all low.
- R2: During reset, `pinIn` is sampled on every rising edge of `clk`. The value captured is the one present at the last rising edge before `rstActive` falls. Earlier values during reset have no effect.
- R3: The capture happens on the first rising edge with `rstActive` low. After that edge, `fsSel` equals `pinIn[2:0]` (bit 2 is the most significant frequency-select bit) and `busSel` equals `pinIn[3]`.
- R4: After the capture, changes on `pinIn` do not alter `fsSel`, `busSel`, the mode outputs or `pinOe` until the next reset.
- R5: `pinOe` stays all zeros on the capture edge. It changes to its run value on the following rising edge, which is the second edge after release.
- R6: `configValid` is high for exactly one cycle, starting on the second edge after release, and stays low afterwards until the next release.
- R7: A captured frequency-select code of 3'b110 sets `modeTest` only.
- R8: A captured code of 3'b111 sets `modeTristate` only, and `pinOe` then stays all zeros.
- R9: Captured codes 3'b000 through 3'b101 set `modeNormal` only, and `pinOe` becomes all ones.
- R10: The mode outputs are all low until the second edge after release. From then on, exactly one of them is high.
- R11: A new reset returns the block to sampling. The next release captures fresh pad levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstActive | input | 1 | Power-on reset, active high, asserted asynchronously |
| pinIn | input | 4 | Levels seen on the shared pads: [2:0] frequency select, [3] bus-mode select |
| pinOe | output | 4 | Output enables for the shared pad drivers |
| fsSel | output | 3 | Captured frequency-select code |
| busSel | output | 1 | Captured bus-mode select |
| modeNormal | output | 1 | Normal frequency table selected |
| modeTest | output | 1 | Production test mode selected |
| modeTristate | output | 1 | All clock outputs floating |
| configValid | output | 1 | One-cycle strobe when the configuration becomes usable |

## Verification
The bench walks every one of the 16 strap codes. In each run it drives a decoy value early in reset, so a design that captured the first sample instead of the last one would show the wrong code. It checks the state one edge after release, where a design that enabled the drivers on the capture edge would already show enables high while sampling still overlaps. It checks again one edge later, where a missing or stretched valid strobe, or a tristate code that still turned the drivers on, would show up. It then toggles the pads after release to catch a register that keeps loading, and finally re-asserts reset to confirm that capture happens again.

// File: rtl/strap_latch_pkg.sv
package strap_latch_pkg;

  typedef enum logic [1:0] {
    PH_SAMPLING = 2'd0,
    PH_ARMING   = 2'd1,
    PH_RUNNING  = 2'd2
  } phase_t;

  typedef struct packed {
    logic capture;
    logic enable;
  } strobe_t;

endpackage

// File: rtl/strap_latch_ctl.sv
module strap_latch_ctl
  import strap_latch_pkg::*;
(
  input  logic    clk,
  input  logic    rstActive,
  output strobe_t strobe,
  output logic    configValid
);

  phase_t phase;
  logic   validReg;

  always_ff @(posedge clk or posedge rstActive) begin
    if (rstActive) begin
      phase    <= PH_SAMPLING;
      validReg <= 1'b0;
    end else begin
      validReg <= (phase == PH_ARMING);
      case (phase)
        PH_SAMPLING: phase <= PH_ARMING;
        PH_ARMING:   phase <= PH_RUNNING;
        default:     phase <= PH_RUNNING;
      endcase
    end
  end

  always_comb begin
    strobe.capture = (phase == PH_SAMPLING);
    strobe.enable  = (phase == PH_ARMING);
  end

  assign configValid = validReg;

  // R6: the valid strobe lasts a single cycle
  p_valid_single_r6: assert property (@(posedge clk) disable iff (rstActive)
    configValid |=> !configValid);

  // R6: once running, the strobe never comes back
  p_valid_once_r6: assert property (@(posedge clk) disable iff (rstActive)
    (phase == PH_RUNNING && !configValid) |=> !configValid);

endmodule

// File: rtl/strap_latch_dp.sv
module strap_latch_dp
  import strap_latch_pkg::*;
#(
  parameter int FS_W = 3
) (
  input  logic            clk,
  input  logic            rstActive,
  input  logic [FS_W:0]   pinIn,
  input  strobe_t         strobe,
  output logic [FS_W:0]   pinOe,
  output logic [FS_W-1:0] fsSel,
  output logic            busSel,
  output logic            modeNormal,
  output logic            modeTest,
  output logic            modeTristate
);

  localparam int NPIN = FS_W + 1;
  localparam logic [FS_W-1:0] TRI_CODE  = '1;
  localparam logic [FS_W-1:0] TEST_CODE = TRI_CODE ^ {{(FS_W-1){1'b0}}, 1'b1};

  logic [NPIN-1:0] sampleReg;
  logic [NPIN-1:0] cfgReg;
  logic [NPIN-1:0] oeReg;
  logic            liveReg;
  logic            codeTri;
  logic            codeTest;

  // Pad levels follow the pins for as long as reset is held
  always_ff @(posedge clk) begin
    if (rstActive) sampleReg <= pinIn;
  end

  always_ff @(posedge clk or posedge rstActive) begin
    if (rstActive)           cfgReg <= '0;
    else if (strobe.capture) cfgReg <= sampleReg;
  end

  assign codeTri  = (cfgReg[FS_W-1:0] == TRI_CODE);
  assign codeTest = (cfgReg[FS_W-1:0] == TEST_CODE);

  always_ff @(posedge clk or posedge rstActive) begin
    if (rstActive)          liveReg <= 1'b0;
    else if (strobe.enable) liveReg <= 1'b1;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_oe
    always_ff @(posedge clk or posedge rstActive) begin
      if (rstActive)          oeReg[i] <= 1'b0;
      else if (strobe.enable) oeReg[i] <= !codeTri;
    end
  end

  assign pinOe        = oeReg;
  assign fsSel        = cfgReg[FS_W-1:0];
  assign busSel       = cfgReg[FS_W];
  assign modeTristate = liveReg & codeTri;
  assign modeTest     = liveReg & codeTest;
  assign modeNormal   = liveReg & !codeTri & !codeTest;

  // R1: drivers are off whenever reset is seen at a clock edge
  always @(posedge clk) begin
    if (rstActive) p_oe_off_reset_r1: assert (oeReg == '0);
  end

  // R4: the configuration register holds once the block is live
  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (rstActive)
    liveReg |=> $stable(cfgReg));

  // R10: at most one mode is reported
  p_mode_onehot_r10: assert property (@(posedge clk) disable iff (rstActive)
    $onehot0({modeNormal, modeTest, modeTristate}));

  // R8: a floating configuration never enables a driver
  p_tri_no_oe_r8: assert property (@(posedge clk) disable iff (rstActive)
    modeTristate |-> (pinOe == '0));

  // R5: enables only change on the arming step
  p_oe_step_r5: assert property (@(posedge clk) disable iff (rstActive)
    !strobe.enable |=> $stable(oeReg));

endmodule

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl
  import strap_latch_pkg::*;
#(
  parameter int FS_W = 3
) (
  input  logic            clk,
  input  logic            rstActive,
  input  logic [FS_W:0]   pinIn,
  output logic [FS_W:0]   pinOe,
  output logic [FS_W-1:0] fsSel,
  output logic            busSel,
  output logic            modeNormal,
  output logic            modeTest,
  output logic            modeTristate,
  output logic            configValid
);

  strobe_t strobe;

  strap_latch_ctl u_ctl (
    .clk         (clk),
    .rstActive   (rstActive),
    .strobe      (strobe),
    .configValid (configValid)
  );

  strap_latch_dp #(.FS_W(FS_W)) u_dp (
    .clk          (clk),
    .rstActive    (rstActive),
    .pinIn        (pinIn),
    .strobe       (strobe),
    .pinOe        (pinOe),
    .fsSel        (fsSel),
    .busSel       (busSel),
    .modeNormal   (modeNormal),
    .modeTest     (modeTest),
    .modeTristate (modeTristate)
  );

endmodule

// File: tb/strap_latch_ctrl_test.sv
module strap_latch_ctrl_test;

  logic       clk = 1'b0;
  logic       rstActive = 1'b1;
  logic [3:0] pinIn = 4'h0;
  logic [3:0] pinOe;
  logic [2:0] fsSel;
  logic       busSel, modeNormal, modeTest, modeTristate, configValid;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  strap_latch_ctrl uut (
    .clk(clk), .rstActive(rstActive), .pinIn(pinIn), .pinOe(pinOe),
    .fsSel(fsSel), .busSel(busSel), .modeNormal(modeNormal),
    .modeTest(modeTest), .modeTristate(modeTristate), .configValid(configValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [2:0] modeVec(input logic [2:0] fs);
    if (fs == 3'b111)      return 3'b001;
    else if (fs == 3'b110) return 3'b010;
    else                   return 3'b100;
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step();
    check("R1 oe in reset", {28'd0, pinOe}, 32'd0);
    check("R1 valid in reset", {31'd0, configValid}, 32'd0);
    check("R1 modes in reset", {29'd0, modeNormal, modeTest, modeTristate}, 32'd0);

    for (int code = 0; code < 16; code++) begin
      logic [3:0] c;
      logic [2:0] expMode;
      logic [3:0] expOe;
      c = code[3:0];
      expMode = modeVec(c[2:0]);
      expOe = (c[2:0] == 3'b111) ? 4'h0 : 4'hF;
      rstActive = 1'b1;
      pinIn = ~c;                       // decoy sampled early in reset
      step(); step();
      check("R1 oe held in reset", {28'd0, pinOe}, 32'd0);
      check("R1 modes held in reset", {29'd0, modeNormal, modeTest, modeTristate}, 32'd0);
      pinIn = c;
      step(); step();
      rstActive = 1'b0;
      step();                           // capture edge
      check("R2 R3 fsSel", {29'd0, fsSel}, {29'd0, c[2:0]});
      check("R3 busSel", {31'd0, busSel}, {31'd0, c[3]});
      check("R5 oe off at capture", {28'd0, pinOe}, 32'd0);
      check("R6 valid low at capture", {31'd0, configValid}, 32'd0);
      check("R10 modes low at capture", {29'd0, modeNormal, modeTest, modeTristate}, 32'd0);
      pinIn = ~c;
      step();                           // enable edge
      check("R5 R8 R9 oe run value", {28'd0, pinOe}, {28'd0, expOe});
      check("R6 valid pulse", {31'd0, configValid}, 32'd1);
      check("R7 R8 R9 R10 mode", {29'd0, modeNormal, modeTest, modeTristate}, {29'd0, expMode});
      for (int k = 0; k < 3; k++) begin
        pinIn = pinIn + 4'd5;
        step();
        check("R6 valid ends", {31'd0, configValid}, 32'd0);
        check("R4 fsSel held", {29'd0, fsSel}, {29'd0, c[2:0]});
        check("R4 busSel held", {31'd0, busSel}, {31'd0, c[3]});
        check("R4 oe held", {28'd0, pinOe}, {28'd0, expOe});
        check("R4 mode held", {29'd0, modeNormal, modeTest, modeTristate}, {29'd0, expMode});
      end
    end

    // R11: a fresh reset captures new levels
    rstActive = 1'b1;
    #1;
    check("R1 R11 oe drops on reset", {28'd0, pinOe}, 32'd0);
    pinIn = 4'b1010;
    step(); step();
    rstActive = 1'b0;
    step(); step();
    check("R11 recapture fsSel", {29'd0, fsSel}, 32'd2);
    check("R11 recapture busSel", {31'd0, busSel}, 32'd1);
    check("R11 recapture valid", {31'd0, configValid}, 32'd1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule